// File: doc/BRIEF.md
# UART Register Front End

This block sits between a 32-bit memory-mapped register bus and the datapath of a UART (receive and transmit FIFOs, serializer, baud divider). It decodes word offsets on a byte address. Four offsets mean one thing when written and another when read. It turns writes of a four-bit command code into single-cycle strobes and level controls. It also holds the sticky receive error and event flags, a five-bit interrupt mask and the CTS tracking logic, and it drives one level-sensitive interrupt line.

Software never clears flags by writing ones into a status word. It writes a coded command instead: one code clears the error flags, another clears the break flag, another clears the CTS-change flag. Other codes reset the receive or transmit FIFO, start or stop a line break, and raise or drop the ready-for-receive output. The enable bits in the low nibble of the same command write switch the receiver and the transmitter on or off.

Top module: `uart_fe_top`

## Requirements
- R1: After reset, irqOut, rfrOut, breakOut, rxEnable, txEnable, rxReset and txReset are 0, baudSel is 0, the mask is all zero, and the four sticky flags are clear.
- R2: A write to byte offset 0x08 loads busWrData[7:0] into baudSel, visible from the next cycle. A read of 0x08 returns the status byte in the same cycle: bit0 rxAvail, bit1 rxFull, bit2 txReady, bit3 txIdle, bit4 overrun flag, bit5 parity/framing flag, bit6 break flag, bit7 huntIn.
- R3: A write to 0x0C raises txPush for that cycle with txData = busWrData[7:0] only when txReady is 1, and otherwise pushes nothing. A read of 0x0C with rxAvail high returns rxData and raises rxPop in the same cycle. With rxAvail low it returns 0 and leaves rxPop low.
- R4: A write to 0x10 takes its command code from busWrData[7:4]. The code's strobe is high for exactly the one cycle after the write edge. Code 1 pulses rxReset and code 2 pulses txReset. Code 0 and the codes 8 to 12 and 15 have no effect.
- R5: In a write to 0x10, bit0 sets rxEnable and bit2 sets txEnable. Bit1 clears rxEnable and bit3 clears txEnable, and a clear bit wins over the set bit for the same side. A write of 0x05 turns both on.
- R6: The overrun flag is set by a one-cycle overrunIn pulse, and the parity/framing flag is set by parFrameErrIn. Each stays set until command code 3 clears both. When a set and that clear land on the same edge, the set wins.
- R7: The break flag is set by breakIn and stays set until command code 4 clears it.
- R8: Command code 5 raises breakOut and code 6 lowers it. Code 13 raises rfrOut and code 14 lowers it. Each output changes at the edge that ends the strobe.
- R9: ctsIn passes through a two-stage synchronizer. The synchronized value is interrupt bit6. A change in the synchronized value sets the sticky CTS-change flag (interrupt bit5) one edge later, and command code 7 clears it.
- R10: A write to 0x14 loads the mask from busWrData bits 0, 3, 4, 5 and 6. A read of 0x14 returns the raw interrupt vector: bit0 txLevelIn, bit3 rxStaleIn, bit4 rxLevelIn, bit5 CTS-change flag, bit6 synchronized CTS. A read of 0x10 returns the raw vector ANDed with the mask.
- R11: irqOut is the OR of the masked interrupt bits. Writing 0 to the mask drops irqOut in the next cycle. Restoring the mask raises it again while a source is still pending.
- R12: Reads of any other offset return 0, and writes to them change nothing. busRdData is 0 whenever busRdEn is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | ADDR_W | Byte address; bits 1:0 ignored |
| busWrEn | input | 1 | Register write this cycle |
| busRdEn | input | 1 | Register read this cycle |
| busWrData | input | DATA_W | Write data |
| busRdData | output | DATA_W | Read data, same cycle |
| rxData | input | BYTE_W | Head byte of the receive FIFO |
| rxAvail | input | 1 | Receive FIFO not empty |
| rxFull | input | 1 | Receive FIFO full |
| rxPop | output | 1 | Pop the receive FIFO |
| rxReset | output | 1 | Receive FIFO/path reset strobe |
| rxEnable | output | 1 | Receiver enable |
| txData | output | BYTE_W | Byte to push into the transmit FIFO |
| txReady | input | 1 | Transmit FIFO can accept a byte |
| txIdle | input | 1 | Transmitter fully empty |
| txPush | output | 1 | Push txData into the transmit FIFO |
| txReset | output | 1 | Transmit FIFO/path reset strobe |
| txEnable | output | 1 | Transmitter enable |
| overrunIn | input | 1 | Receive overrun event pulse |
| parFrameErrIn | input | 1 | Parity or framing error event pulse |
| breakIn | input | 1 | Line break detected pulse |
| huntIn | input | 1 | Hunt character matched |
| rxLevelIn | input | 1 | Receive FIFO above its watermark |
| rxStaleIn | input | 1 | Receive data stale timeout |
| txLevelIn | input | 1 | Transmit FIFO below its watermark |
| ctsIn | input | 1 | Asynchronous clear-to-send line |
| rfrOut | output | 1 | Ready-for-receive line |
| breakOut | output | 1 | Force break on the transmit line |
| baudSel | output | BYTE_W | Baud/clock select code |
| irqOut | output | 1 | Level interrupt |

## Verification
Read data, rxPop, txPush, txData and irqOut follow the bus inputs and current state in the same cycle. baudSel, the mask and the enables move at the write edge. Command strobes are high in the cycle after the write edge, so a clear shows at the edge after that. Event pulses set flags at the next edge, and a ctsIn change needs two edges to reach bit6 and a third edge to set bit5. The bench moves its inputs one time unit after each rising edge. A behavioural model advances at that same rising edge, and every output is compared with the model at the falling edge, so each result is checked in exactly the cycle it becomes due.

// File: rtl/uart_fe_pkg.sv
package uart_fe_pkg;
  // Word indices (byte offset >> 2) with direction-dependent meaning
  localparam int WORD_STATUS = 2;   // 0x08: rd status / wr baud select
  localparam int WORD_FIFO   = 3;   // 0x0C: rd rx byte / wr tx byte
  localparam int WORD_CMD    = 4;   // 0x10: rd masked irq / wr command
  localparam int WORD_MASK   = 5;   // 0x14: rd raw irq / wr mask

  localparam logic [3:0] CMD_RX_RST  = 4'd1;
  localparam logic [3:0] CMD_TX_RST  = 4'd2;
  localparam logic [3:0] CMD_CLR_ERR = 4'd3;
  localparam logic [3:0] CMD_CLR_BRK = 4'd4;
  localparam logic [3:0] CMD_BRK_ON  = 4'd5;
  localparam logic [3:0] CMD_BRK_OFF = 4'd6;
  localparam logic [3:0] CMD_CLR_CTS = 4'd7;
  localparam logic [3:0] CMD_RFR_ON  = 4'd13;
  localparam logic [3:0] CMD_RFR_OFF = 4'd14;

  localparam int IRQ_W      = 7;
  localparam int IRQ_TXLEV  = 0;
  localparam int IRQ_STALE  = 3;
  localparam int IRQ_RXLEV  = 4;
  localparam int IRQ_CTSCHG = 5;
  localparam int IRQ_CTSNOW = 6;
  localparam logic [IRQ_W-1:0] IRQ_USED = 7'b111_1001;

  // sticky flag slots
  localparam int NUM_STICKY = 4;
  localparam int STK_OVR = 0;
  localparam int STK_PFE = 1;
  localparam int STK_BRK = 2;
  localparam int STK_CTS = 3;

  typedef struct packed {
    logic rxReset;
    logic txReset;
    logic clrErr;
    logic clrBrk;
    logic brkOn;
    logic brkOff;
    logic clrCts;
    logic rfrOn;
    logic rfrOff;
  } feStrobes_t;

  typedef struct packed {
    logic wrBaud;
    logic wrTx;
    logic wrMask;
    logic rdStatus;
    logic rdFifo;
    logic rdMasked;
    logic rdRaw;
  } feAccess_t;
endpackage

// File: rtl/uart_fe_ctrl.sv
module uart_fe_ctrl
  import uart_fe_pkg::*;
#(
  parameter int WORD_W = 6,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [WORD_W-1:0] wordAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [BYTE_W-1:0] wrByte,
  output feStrobes_t        strobes,
  output feAccess_t         access,
  output logic              rxEnable,
  output logic              txEnable
);
  logic       wrCmd;
  logic [3:0] cmdCode;
  feStrobes_t nextStrobes;

  assign cmdCode = wrByte[7:4];
  assign wrCmd   = busWrEn && (wordAddr == WORD_W'(WORD_CMD));

  // direction-aliased decode
  always_comb begin
    access          = '0;
    access.wrBaud   = busWrEn && (wordAddr == WORD_W'(WORD_STATUS));
    access.wrTx     = busWrEn && (wordAddr == WORD_W'(WORD_FIFO));
    access.wrMask   = busWrEn && (wordAddr == WORD_W'(WORD_MASK));
    access.rdStatus = busRdEn && (wordAddr == WORD_W'(WORD_STATUS));
    access.rdFifo   = busRdEn && (wordAddr == WORD_W'(WORD_FIFO));
    access.rdMasked = busRdEn && (wordAddr == WORD_W'(WORD_CMD));
    access.rdRaw    = busRdEn && (wordAddr == WORD_W'(WORD_MASK));
  end

  always_comb begin
    nextStrobes = '0;
    if (wrCmd) begin
      case (cmdCode)
        CMD_RX_RST:  nextStrobes.rxReset = 1'b1;
        CMD_TX_RST:  nextStrobes.txReset = 1'b1;
        CMD_CLR_ERR: nextStrobes.clrErr  = 1'b1;
        CMD_CLR_BRK: nextStrobes.clrBrk  = 1'b1;
        CMD_BRK_ON:  nextStrobes.brkOn   = 1'b1;
        CMD_BRK_OFF: nextStrobes.brkOff  = 1'b1;
        CMD_CLR_CTS: nextStrobes.clrCts  = 1'b1;
        CMD_RFR_ON:  nextStrobes.rfrOn   = 1'b1;
        CMD_RFR_OFF: nextStrobes.rfrOff  = 1'b1;
        default:     nextStrobes = '0;
      endcase
    end
  end

  // strobes live for exactly the cycle after the write edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) strobes <= '0;
    else       strobes <= nextStrobes;
  end

  // enable bits: the disable bit of a side wins
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxEnable <= 1'b0;
      txEnable <= 1'b0;
    end else if (wrCmd) begin
      if (wrByte[1])      rxEnable <= 1'b0;
      else if (wrByte[0]) rxEnable <= 1'b1;
      if (wrByte[3])      txEnable <= 1'b0;
      else if (wrByte[2]) txEnable <= 1'b1;
    end
  end

  assert_single_command_R4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobes));

  assert_rx_reset_timing_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobes.rxReset |-> $past(wrCmd && cmdCode == CMD_RX_RST));

  assert_enable_by_command_R5: assert property (@(posedge clk) disable iff (!rstN)
    !$stable({rxEnable, txEnable}) |-> $past(wrCmd));
endmodule

// File: rtl/uart_fe_datapath.sv
module uart_fe_datapath
  import uart_fe_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  feStrobes_t        strobes,
  input  feAccess_t         access,
  input  logic [BYTE_W-1:0] wrByte,
  input  logic [BYTE_W-1:0] rxData,
  input  logic              rxAvail,
  input  logic              rxFull,
  input  logic              txReady,
  input  logic              txIdle,
  input  logic              overrunIn,
  input  logic              parFrameErrIn,
  input  logic              breakIn,
  input  logic              huntIn,
  input  logic              rxLevelIn,
  input  logic              rxStaleIn,
  input  logic              txLevelIn,
  input  logic              ctsIn,
  output logic [DATA_W-1:0] busRdData,
  output logic              rxPop,
  output logic              txPush,
  output logic [BYTE_W-1:0] txData,
  output logic              rxReset,
  output logic              txReset,
  output logic [BYTE_W-1:0] baudSel,
  output logic              breakOut,
  output logic              rfrOut,
  output logic              irqOut
);
  logic [1:0]            ctsSync;
  logic                  ctsLast;
  logic                  ctsChange;
  logic [NUM_STICKY-1:0] stickySet, stickyClr, sticky;
  logic [IRQ_W-1:0]      maskQ, rawIrq, maskedIrq;
  logic [7:0]            statusByte;

  assign rxReset = strobes.rxReset;
  assign txReset = strobes.txReset;

  // CTS synchronizer and change detect
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctsSync <= '0;
      ctsLast <= 1'b0;
    end else begin
      ctsSync <= {ctsSync[0], ctsIn};
      ctsLast <= ctsSync[1];
    end
  end
  assign ctsChange = ctsSync[1] ^ ctsLast;

  always_comb begin
    stickySet          = '0;
    stickyClr          = '0;
    stickySet[STK_OVR] = overrunIn;
    stickySet[STK_PFE] = parFrameErrIn;
    stickySet[STK_BRK] = breakIn;
    stickySet[STK_CTS] = ctsChange;
    stickyClr[STK_OVR] = strobes.clrErr;
    stickyClr[STK_PFE] = strobes.clrErr;
    stickyClr[STK_BRK] = strobes.clrBrk;
    stickyClr[STK_CTS] = strobes.clrCts;
  end

  // sticky flags: a new event wins over a same-edge clear
  for (genvar gi = 0; gi < NUM_STICKY; gi++) begin : g_sticky
    logic flagQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)              flagQ <= 1'b0;
      else if (stickySet[gi]) flagQ <= 1'b1;
      else if (stickyClr[gi]) flagQ <= 1'b0;
    end
    assign sticky[gi] = flagQ;
  end

  // line controls driven by command strobes
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      breakOut <= 1'b0;
      rfrOut   <= 1'b0;
    end else begin
      if (strobes.brkOn)       breakOut <= 1'b1;
      else if (strobes.brkOff) breakOut <= 1'b0;
      if (strobes.rfrOn)       rfrOut <= 1'b1;
      else if (strobes.rfrOff) rfrOut <= 1'b0;
    end
  end

  // write-side registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baudSel <= '0;
      maskQ   <= '0;
    end else begin
      if (access.wrBaud) baudSel <= wrByte;
      if (access.wrMask) maskQ <= wrByte[IRQ_W-1:0] & IRQ_USED;
    end
  end

  always_comb begin
    rawIrq             = '0;
    rawIrq[IRQ_TXLEV]  = txLevelIn;
    rawIrq[IRQ_STALE]  = rxStaleIn;
    rawIrq[IRQ_RXLEV]  = rxLevelIn;
    rawIrq[IRQ_CTSCHG] = sticky[STK_CTS];
    rawIrq[IRQ_CTSNOW] = ctsSync[1];
  end
  assign maskedIrq = rawIrq & maskQ;
  assign irqOut    = |maskedIrq;

  assign statusByte = {huntIn, sticky[STK_BRK], sticky[STK_PFE], sticky[STK_OVR],
                       txIdle, txReady, rxFull, rxAvail};

  assign rxPop  = access.rdFifo && rxAvail;
  assign txPush = access.wrTx && txReady;
  assign txData = wrByte;

  always_comb begin
    busRdData = '0;
    if (access.rdStatus)      busRdData[7:0]        = statusByte;
    else if (access.rdFifo)   busRdData[BYTE_W-1:0] = rxAvail ? rxData : '0;
    else if (access.rdMasked) busRdData[IRQ_W-1:0]  = maskedIrq;
    else if (access.rdRaw)    busRdData[IRQ_W-1:0]  = rawIrq;
  end

  assert_overrun_sticky_R6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sticky[STK_OVR]) |-> $past(strobes.clrErr));

  assert_rfr_by_command_R8: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(rfrOut) |-> $past(strobes.rfrOn || strobes.rfrOff));

  assert_cts_flag_source_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sticky[STK_CTS]) |-> $past(ctsSync[1] != ctsLast));

  assert_pop_needs_data_R3: assert property (@(posedge clk) disable iff (!rstN)
    rxPop |-> rxAvail);

  assert_zero_mask_drops_irq_R11: assert property (@(posedge clk) disable iff (!rstN)
    $past(access.wrMask && wrByte[IRQ_W-1:0] == '0) |-> !irqOut);
endmodule

// File: rtl/uart_fe_top.sv
module uart_fe_top
  import uart_fe_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  input  logic [BYTE_W-1:0] rxData,
  input  logic              rxAvail,
  input  logic              rxFull,
  output logic              rxPop,
  output logic              rxReset,
  output logic              rxEnable,
  output logic [BYTE_W-1:0] txData,
  input  logic              txReady,
  input  logic              txIdle,
  output logic              txPush,
  output logic              txReset,
  output logic              txEnable,
  input  logic              overrunIn,
  input  logic              parFrameErrIn,
  input  logic              breakIn,
  input  logic              huntIn,
  input  logic              rxLevelIn,
  input  logic              rxStaleIn,
  input  logic              txLevelIn,
  input  logic              ctsIn,
  output logic              rfrOut,
  output logic              breakOut,
  output logic [BYTE_W-1:0] baudSel,
  output logic              irqOut
);
  localparam int WORD_W = ADDR_W - 2;

  feStrobes_t        strobes;
  feAccess_t         access;
  logic [BYTE_W-1:0] wrByte;
  logic              unusedBits;

  assign wrByte     = busWrData[BYTE_W-1:0];
  assign unusedBits = ^{busAddr[1:0], busWrData[DATA_W-1:BYTE_W]};

  uart_fe_ctrl #(.WORD_W(WORD_W), .BYTE_W(BYTE_W)) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .wordAddr (busAddr[ADDR_W-1:2]),
    .busWrEn  (busWrEn),
    .busRdEn  (busRdEn),
    .wrByte   (wrByte),
    .strobes  (strobes),
    .access   (access),
    .rxEnable (rxEnable),
    .txEnable (txEnable)
  );

  uart_fe_datapath #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) i_datapath (
    .clk           (clk),
    .rstN          (rstN),
    .strobes       (strobes),
    .access        (access),
    .wrByte        (wrByte),
    .rxData        (rxData),
    .rxAvail       (rxAvail),
    .rxFull        (rxFull),
    .txReady       (txReady),
    .txIdle        (txIdle),
    .overrunIn     (overrunIn),
    .parFrameErrIn (parFrameErrIn),
    .breakIn       (breakIn),
    .huntIn        (huntIn),
    .rxLevelIn     (rxLevelIn),
    .rxStaleIn     (rxStaleIn),
    .txLevelIn     (txLevelIn),
    .ctsIn         (ctsIn),
    .busRdData     (busRdData),
    .rxPop         (rxPop),
    .txPush        (txPush),
    .txData        (txData),
    .rxReset       (rxReset),
    .txReset       (txReset),
    .baudSel       (baudSel),
    .breakOut      (breakOut),
    .rfrOut        (rfrOut),
    .irqOut        (irqOut)
  );
endmodule

// File: tb/test_uart_fe_top.sv
module test_uart_fe_top;
  localparam int CLK_PERIOD      = 10;
  localparam int WATCHDOG_CYCLES = 20000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  busAddr = '0;
  logic        busWrEn = 1'b0, busRdEn = 1'b0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic [7:0]  rxData = '0;
  logic        rxAvail = 0, rxFull = 0, txReady = 0, txIdle = 0;
  logic        overrunIn = 0, parFrameErrIn = 0, breakIn = 0, huntIn = 0;
  logic        rxLevelIn = 0, rxStaleIn = 0, txLevelIn = 0, ctsIn = 0;
  logic        rxPop, rxReset, rxEnable, txPush, txReset, txEnable;
  logic [7:0]  txData, baudSel;
  logic        rfrOut, breakOut, irqOut;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_fe_top i_uart_fe_top (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busWrData(busWrData), .busRdData(busRdData), .rxData(rxData), .rxAvail(rxAvail),
    .rxFull(rxFull), .rxPop(rxPop), .rxReset(rxReset), .rxEnable(rxEnable),
    .txData(txData), .txReady(txReady), .txIdle(txIdle), .txPush(txPush),
    .txReset(txReset), .txEnable(txEnable), .overrunIn(overrunIn),
    .parFrameErrIn(parFrameErrIn), .breakIn(breakIn), .huntIn(huntIn),
    .rxLevelIn(rxLevelIn), .rxStaleIn(rxStaleIn), .txLevelIn(txLevelIn), .ctsIn(ctsIn),
    .rfrOut(rfrOut), .breakOut(breakOut), .baudSel(baudSel), .irqOut(irqOut)
  );

  int    checks = 0;
  int    fails = 0;
  bit    finished = 0;
  string curTag = "R1";

  // behavioural reference state
  int         mCmd = 0;
  bit         mOvr = 0, mPfe = 0, mBrkF = 0, mCtsChg = 0;
  bit         mSync0 = 0, mSync1 = 0, mCtsLast = 0;
  bit         mRxEn = 0, mTxEn = 0, mBrkOut = 0, mRfr = 0;
  logic [7:0] mBaud = '0;
  logic [6:0] mMask = '0;

  always @(posedge clk) begin
    if (!rstN) begin
      mCmd = 0; mOvr = 0; mPfe = 0; mBrkF = 0; mCtsChg = 0;
      mSync0 = 0; mSync1 = 0; mCtsLast = 0;
      mRxEn = 0; mTxEn = 0; mBrkOut = 0; mRfr = 0; mBaud = '0; mMask = '0;
    end else begin
      if (overrunIn) mOvr = 1; else if (mCmd == 3) mOvr = 0;
      if (parFrameErrIn) mPfe = 1; else if (mCmd == 3) mPfe = 0;
      if (breakIn) mBrkF = 1; else if (mCmd == 4) mBrkF = 0;
      if (mSync1 != mCtsLast) mCtsChg = 1; else if (mCmd == 7) mCtsChg = 0;
      mCtsLast = mSync1; mSync1 = mSync0; mSync0 = ctsIn;
      if (mCmd == 5) mBrkOut = 1; else if (mCmd == 6) mBrkOut = 0;
      if (mCmd == 13) mRfr = 1; else if (mCmd == 14) mRfr = 0;
      mCmd = 0;
      if (busWrEn) begin
        case (busAddr[7:2])
          6'd2: mBaud = busWrData[7:0];
          6'd4: begin
            mCmd = int'(busWrData[7:4]);
            if (busWrData[1]) mRxEn = 0; else if (busWrData[0]) mRxEn = 1;
            if (busWrData[3]) mTxEn = 0; else if (busWrData[2]) mTxEn = 1;
          end
          6'd5: mMask = busWrData[6:0] & 7'b111_1001;
          default: ;
        endcase
      end
    end
  end

  task automatic chk(input string tag, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  logic [7:0]  stE;
  logic [6:0]  rawE, mskE;
  logic [31:0] rdE;
  bit          popE, pushE;

  always @(negedge clk) begin
    if (!finished) begin
      stE  = {huntIn, mBrkF, mPfe, mOvr, txIdle, txReady, rxFull, rxAvail};
      rawE = '0;
      rawE[0] = txLevelIn; rawE[3] = rxStaleIn; rawE[4] = rxLevelIn;
      rawE[5] = mCtsChg;   rawE[6] = mSync1;
      mskE = rawE & mMask;
      rdE  = '0;
      if (busRdEn) begin
        case (busAddr[7:2])
          6'd2: rdE = {24'd0, stE};
          6'd3: rdE = rxAvail ? {24'd0, rxData} : 32'd0;
          6'd4: rdE = {25'd0, mskE};
          6'd5: rdE = {25'd0, rawE};
          default: rdE = '0;
        endcase
      end
      popE  = busRdEn && busAddr[7:2] == 6'd3 && rxAvail;
      pushE = busWrEn && busAddr[7:2] == 6'd3 && txReady;
      chk(curTag, "busRdData", busRdData, rdE);
      chk("R11", "irqOut", {31'd0, irqOut}, {31'd0, |mskE});
      chk("R8", "rfrOut", {31'd0, rfrOut}, {31'd0, mRfr});
      chk("R8", "breakOut", {31'd0, breakOut}, {31'd0, mBrkOut});
      chk("R5", "rxEnable", {31'd0, rxEnable}, {31'd0, mRxEn});
      chk("R5", "txEnable", {31'd0, txEnable}, {31'd0, mTxEn});
      chk("R2", "baudSel", {24'd0, baudSel}, {24'd0, mBaud});
      chk("R4", "rxReset", {31'd0, rxReset}, {31'd0, mCmd == 1});
      chk("R4", "txReset", {31'd0, txReset}, {31'd0, mCmd == 2});
      chk("R3", "rxPop", {31'd0, rxPop}, {31'd0, popE});
      chk("R3", "txPush", {31'd0, txPush}, {31'd0, pushE});
      if (pushE) chk("R3", "txData", {24'd0, txData}, {24'd0, busWrData[7:0]});
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic doWrite(input logic [7:0] a, input logic [31:0] d);
    step();
    busAddr = a; busWrData = d; busWrEn = 1; busRdEn = 0;
    step();
    busWrEn = 0;
  endtask

  task automatic doRead(input logic [7:0] a);
    step();
    busAddr = a; busRdEn = 1; busWrEn = 0;
    step();
    busRdEn = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finished = 1;
      summary();
      $finish;
    end
  end

  initial begin
    // R1: reset values are compared every cycle while reset is held
    curTag = "R1";
    idle(3);
    rstN = 1;
    idle(2);

    // R2: baud select write and status byte reads
    curTag = "R2";
    doWrite(8'h08, 32'hFFFF_FFA5);
    rxAvail = 1; rxFull = 1; txIdle = 1; huntIn = 1;
    doRead(8'h08);
    rxAvail = 0; rxFull = 0; txReady = 1; txIdle = 0; huntIn = 0;
    doRead(8'h08);
    doWrite(8'h08, 32'h0000_003C);

    // R3: FIFO offset in both directions
    curTag = "R3";
    rxAvail = 1; rxData = 8'h3C;
    doRead(8'h0C);
    rxData = 8'hE1;
    doRead(8'h0C);
    rxAvail = 0;
    doRead(8'h0C);
    txReady = 1;
    doWrite(8'h0C, 32'h0000_0155);
    txReady = 0;
    doWrite(8'h0C, 32'h0000_00AA);
    txReady = 1;

    // R4: command strobes, including no-op and unused codes
    curTag = "R4";
    doWrite(8'h10, 32'h10);
    doWrite(8'h10, 32'h20);
    doWrite(8'h10, 32'h00);
    doWrite(8'h10, 32'hF0);
    doWrite(8'h10, 32'h80);
    idle(2);

    // R5: enable and disable bits
    curTag = "R5";
    doWrite(8'h10, 32'h05);
    doWrite(8'h10, 32'h02);
    doWrite(8'h10, 32'h0C);
    doWrite(8'h10, 32'h05);

    // R6: overrun and parity/framing flags stay until code 3; set beats clear
    curTag = "R6";
    step(); overrunIn = 1; step(); overrunIn = 0;
    idle(3);
    doRead(8'h08);
    step(); parFrameErrIn = 1; step(); parFrameErrIn = 0;
    doRead(8'h08);
    doWrite(8'h10, 32'h35);
    idle(1);
    doRead(8'h08);
    step(); overrunIn = 1; step(); overrunIn = 0;
    doWrite(8'h10, 32'h30);
    overrunIn = 1; step(); overrunIn = 0;
    doRead(8'h08);
    doWrite(8'h10, 32'h30);
    idle(1);
    doRead(8'h08);

    // R7: break flag and its own clear code
    curTag = "R7";
    step(); breakIn = 1; step(); breakIn = 0;
    doWrite(8'h10, 32'h30);
    doRead(8'h08);
    doWrite(8'h10, 32'h40);
    idle(1);
    doRead(8'h08);

    // R8: break and RFR line controls
    curTag = "R8";
    doWrite(8'h10, 32'h50);
    doWrite(8'h10, 32'hD0);
    idle(2);
    doWrite(8'h10, 32'h60);
    doWrite(8'h10, 32'hE0);
    doWrite(8'h10, 32'hD0);
    idle(2);

    // R9: CTS synchronization, change flag, clear with code 7
    curTag = "R9";
    step(); ctsIn = 1;
    for (int i = 0; i < 4; i++) doRead(8'h14);
    doWrite(8'h10, 32'h70);
    idle(1);
    doRead(8'h14);
    step(); ctsIn = 0;
    idle(4);
    doRead(8'h14);

    // R10: mask load, raw and masked views
    curTag = "R10";
    txLevelIn = 1; rxStaleIn = 1; rxLevelIn = 0;
    doWrite(8'h14, 32'h0000_00FF);
    doRead(8'h14);
    doRead(8'h10);
    doWrite(8'h14, 32'h0000_0011);
    doRead(8'h10);
    rxLevelIn = 1;
    doRead(8'h10);

    // R11: zero mask drops the line, restore brings it back
    curTag = "R11";
    doWrite(8'h14, 32'h0);
    idle(2);
    doWrite(8'h14, 32'h11);
    idle(2);
    rxLevelIn = 0; txLevelIn = 0;
    idle(2);
    doWrite(8'h10, 32'h70);
    doWrite(8'h14, 32'h60);
    idle(2);

    // R12: unmapped offsets and idle bus
    curTag = "R12";
    rxAvail = 1; rxData = 8'h77;
    doRead(8'h00);
    doRead(8'h04);
    doRead(8'h18);
    doRead(8'hFC);
    doWrite(8'h00, 32'h0000_00D5);
    doWrite(8'h18, 32'h0000_0050);
    doWrite(8'h04, 32'h0000_0011);
    busAddr = 8'h0C;
    idle(3);
    rxAvail = 0;
    idle(2);

    finished = 1;
    summary();
    $finish;
  end
endmodule